// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned 4-bit operands and gives an 8-bit product. It does not add shifted partial-product rows. It works one result column at a time. Each column collects every AND term `a[i] & b[j]` whose index sum `i + j` equals the column number. It adds that count to the carry coming in from the column below. Bit 0 of the column sum becomes the product bit for that column, and the higher bits move up as a multi-bit carry. Column 0 has only the single term `a[0] & b[0]` and no carry. The carry left over after the highest column becomes the top product bit.

The product is available on a purely combinational output. The same value can also be taken from a registered output. That register loads one clock edge after the operands are presented with `inValid` high, and `outValid` is high in the cycle the loaded value appears. A synchronous active-high reset clears the registered product and `outValid`.

Top module: `vcm_mult`

## Requirements
- R1: `comboP[0]` always equals `a[0] & b[0]`.
- R2: For column k from 1 to 6, `comboP[k]` is bit 0 of the count of AND terms with `i + j = k` plus the carry out of column k-1. The carry is the column sum shifted right by one. Columns 1 to 6 hold 2, 3, 4, 3, 2 and 1 terms.
- R3: `comboP[7]` is the carry left over after column 6. It can be 1 only when `a[3]` and `b[3]` are both 1, and no carry bit above it is ever set.
- R4: `comboP` equals the unsigned product `a * b` for all 256 operand pairs.
- R5: `a = 4'b1101` and `b = 4'b1001` give `comboP = 8'b01110101`.
- R6: When `inValid` is high at a rising clock edge and `rst` is low, `p` takes the value `comboP` had at that edge, and `outValid` is high after that edge.
- R7: When `inValid` is low at an edge and `rst` is low, `p` keeps its value and `outValid` goes low.
- R8: `rst` high at an edge sets `p` to 0 and `outValid` to 0.
- R9: When `rst` and `inValid` are both high at the same edge, the reset wins: `p` becomes 0 and `outValid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands on `a`/`b` are to be captured at this edge |
| a | input | 4 | Unsigned multiplicand |
| b | input | 4 | Unsigned multiplier |
| comboP | output | 8 | Combinational product |
| p | output | 8 | Registered product |
| outValid | output | 1 | `p` was loaded at the previous edge |

## Verification
A capture request and a synchronous reset can arrive at the same clock edge. The bench raises `rst` and `inValid` together with non-zero operands. It then requires a zero product, a low `outValid`, and no entry placed in the scoreboard. Capture is also exercised back to back across the full operand sweep, so the load path is judged on every cycle against the queued products. The combinational output is compared in the same cycle against the arithmetic product.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  parameter int OP_W = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int COLS = 2 * OP_W - 1;
  // Column sum never exceeds OP_W terms plus a carry below OP_W.
  localparam int SUM_W = $clog2(2 * OP_W) + 1;

  typedef struct packed {
    logic capture;
    logic clear;
  } regStrobe_t;
endpackage

// File: rtl/vcm_column.sv
module vcm_column #(
  parameter int TERMS = 1,
  parameter int SUM_W = 4
) (
  input  logic [TERMS-1:0] termVec,
  input  logic [SUM_W-1:0] carryIn,
  output logic             sumBit,
  output logic [SUM_W-1:0] carryOut
);
  logic [SUM_W-1:0] colSum;

  always_comb begin
    colSum = carryIn;
    for (int t = 0; t < TERMS; t++) begin
      colSum = colSum + SUM_W'(termVec[t]);
    end
  end

  assign sumBit   = colSum[0];
  assign carryOut = colSum >> 1;
endmodule

// File: rtl/vcm_datapath.sv
module vcm_datapath
  import vcm_pkg::*;
(
  input  logic              clk,
  input  regStrobe_t        strobe,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [PROD_W-1:0] comboP,
  output logic [PROD_W-1:0] p,
  output logic [SUM_W-2:0]  carryResidue
);
  logic [SUM_W-1:0] carryChain [0:COLS];

  assign carryChain[0] = '0;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    localparam int LO    = (k < OP_W) ? 0 : k - OP_W + 1;
    localparam int HI    = (k < OP_W) ? k : OP_W - 1;
    localparam int TERMS = HI - LO + 1;
    logic [TERMS-1:0] termVec;

    for (genvar t = 0; t < TERMS; t++) begin : g_term
      assign termVec[t] = a[LO+t] & b[k-LO-t];
    end

    vcm_column #(.TERMS(TERMS), .SUM_W(SUM_W)) u_col (
      .termVec (termVec),
      .carryIn (carryChain[k]),
      .sumBit  (comboP[k]),
      .carryOut(carryChain[k+1])
    );
  end

  assign comboP[PROD_W-1] = carryChain[COLS][0];
  assign carryResidue     = carryChain[COLS][SUM_W-1:1];

  always_ff @(posedge clk) begin
    if (strobe.clear) p <= '0;
    else if (strobe.capture) p <= comboP;
  end
endmodule

// File: rtl/vcm_control.sv
module vcm_control
  import vcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output regStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else outValid <= inValid;
  end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult
  import vcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [PROD_W-1:0] comboP,
  output logic [PROD_W-1:0] p,
  output logic              outValid
);
  regStrobe_t strobe;
  logic [SUM_W-2:0] carryResidue;

  vcm_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  vcm_datapath u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .a           (a),
    .b           (b),
    .comboP      (comboP),
    .p           (p),
    .carryResidue(carryResidue)
  );
endmodule

// File: rtl/vcm_mult_checker.sv
module vcm_mult_checker
  import vcm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OP_W-1:0]   a,
  input logic [OP_W-1:0]   b,
  input logic [PROD_W-1:0] comboP,
  input logic [PROD_W-1:0] p,
  input logic              outValid,
  input logic [SUM_W-2:0]  carryResidue
);
  a_r1_lsb_vertical: assert property (@(posedge clk) disable iff (rst)
    comboP[0] == (a[0] & b[0]));

  a_r4_full_product: assert property (@(posedge clk) disable iff (rst)
    comboP == PROD_W'(a) * PROD_W'(b));

  a_r3_top_needs_msbs: assert property (@(posedge clk) disable iff (rst)
    comboP[PROD_W-1] |-> (a[OP_W-1] && b[OP_W-1]));

  a_r3_no_residue: assert property (@(posedge clk) disable iff (rst)
    carryResidue == '0);

  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outValid && p == $past(comboP)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(p)));

  a_r8_clear: assert property (@(posedge clk)
    rst |=> (p == '0 && !outValid));
endmodule

bind vcm_mult vcm_mult_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .a           (a),
  .b           (b),
  .comboP      (comboP),
  .p           (p),
  .outValid    (outValid),
  .carryResidue(carryResidue)
);

// File: tb/sim_vcm_mult.sv
module sim_vcm_mult;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [3:0] a = '0;
  logic [3:0] b = '0;
  logic [7:0] comboP, p;
  logic       outValid;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  logic [7:0] lastCaptured = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcm_mult u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .a(a), .b(b),
    .comboP(comboP), .p(p), .outValid(outValid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: present operands at the falling edge, check the combinational path.
  task automatic drive(input logic [3:0] av, input logic [3:0] bv, input logic v, input logic r);
    logic [7:0] exp;
    @(negedge clk);
    a = av; b = bv; inValid = v; rst = r;
    #1;
    exp = 8'(av) * 8'(bv);
    check("R4", comboP, exp);
    check("R1", {7'b0, comboP[0]}, {7'b0, av[0] & bv[0]});
    check("R3", {7'b0, comboP[7]}, {7'b0, exp[7]});
    if (v && !r) begin
      expQ.push_back(exp);
      lastCaptured = exp;
    end
  endtask

  // Monitor: pops the expected product whenever the register reports valid.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (outValid) begin
        if (expQ.size() == 0) check("R6 unexpected outValid", 8'd1, 8'd0);
        else check("R6", p, expQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R8 reset p", p, 8'd0);
    check("R8 reset outValid", {7'b0, outValid}, 8'd0);

    // R5 directed pattern
    drive(4'b1101, 4'b1001, 1'b1, 1'b0);
    check("R5", comboP, 8'b01110101);

    // R2 column carries: all ones stresses the 4-term column
    drive(4'hF, 4'hF, 1'b1, 1'b0);
    check("R2", comboP, 8'd225);
    drive(4'h8, 4'h8, 1'b1, 1'b0);
    check("R2", comboP, 8'd64);

    // R4 and R6 exhaustive back-to-back captures
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 16; bi++)
        drive(4'(ai), 4'(bi), 1'b1, 1'b0);

    // R7 hold with changed operands
    drive(4'h7, 4'h5, 1'b1, 1'b0);
    drive(4'h3, 4'h2, 1'b0, 1'b0);
    @(posedge clk); #2;
    check("R7 hold p", p, 8'd35);
    check("R7 outValid low", {7'b0, outValid}, 8'd0);

    // R9 reset and capture together
    drive(4'hE, 4'hD, 1'b1, 1'b1);
    @(posedge clk); #2;
    check("R9 p cleared", p, 8'd0);
    check("R9 outValid low", {7'b0, outValid}, 8'd0);

    // R8 reset after a capture
    drive(4'h9, 4'h9, 1'b1, 1'b0);
    drive(4'h0, 4'h0, 1'b0, 1'b1);
    @(posedge clk); #2;
    check("R8 mid-run p", p, 8'd0);
    drive(4'h0, 4'h0, 1'b0, 1'b0);
    @(posedge clk); #2;
    check("R6 queue drained", 8'(expQ.size()), 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule